// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a bit-serial configuration store that feeds a programmable logic device loading itself in master-serial fashion. An internal bit address counter steps once per configuration clock. The bit at the current address goes out on a single data pin, with its own enable so that a shared line can be modelled as tri-state. Read-out is gated by an active-low chip select and by a combined reset/enable input. The level that counts as "reset" on that input is chosen at power-on reset.

Several instances can be chained. Each block drives an active-low chain output that selects the next block once its own contents have been sent. The chain therefore streams one unbroken bitstream. A serial-enable input moves the block into a programming mode. In that mode read-out stops, and a simple synchronous word-wide load port fills the store.

The store is organised in words of `WORD_W` bits, so it can map onto block RAM. Bit address `a` lives in word `a / WORD_W`, at bit position `a % WORD_W`, and the least significant bit of a word is sent first. `DEPTH` is the number of bits: 65,536 by default, with 131,072 or 262,144 as the intended alternatives.

Top module: `serial_cfg_reader`

## Requirements
- R1: After `rst` (synchronous, active high), the address counter is 0 and the end-of-memory flag is clear. With `ce_n` high, `dout_en` is 0 and `ceo_n` is 1.
- R2: While `ser_en` is 1 and `roe` is at its reset level, the counter returns to 0 and the end flag clears at each clock, whatever `ce_n` is. `dout_en` is 0 during this time. When the enable level returns (with `ce_n` low), bit 0 is presented at once.
- R3: `pol_sel` is sampled only while `rst` is high. With 0, `roe` low means reset and `roe` high means enable. With 1, the meaning is inverted. Changes on `pol_sel` outside reset have no effect.
- R4: While `ser_en` is 1, `ce_n` is 0, `roe` is at its enable level and the end flag is clear, `dout_en` is 1 and `dout` carries the bit at the current address. Each clock then advances the address by one. The first bit after a reset is bit 0.
- R5: While `ce_n` is 1 (and `roe` is not at its reset level), `dout_en` is 0 and the counter is frozen. Read-out resumes with the next unsent bit.
- R6: The clock that sends bit `DEPTH-1` sets the end flag. From then on, `dout_en` stays 0 and the counter stays put until a reset level is seen on `roe`.
- R7: `ceo_n` is 0 exactly when the end flag is set and `ce_n` is 0. It follows `ce_n` while the end flag is set. After a reset level on `roe`, it stays 1 until the whole memory has been sent again.
- R8: While `ser_en` is 0, `dout_en` is 0, the counter and end flag hold, and `ce_n` and `roe` are ignored. Leaving this mode resumes at the held address. `load_we` writes `load_word` into word `load_addr`, and the contents survive `rst`.
- R9: When two blocks are chained (the first block's `ceo_n` drives the second block's `ce_n`), the second block's bit 0 appears in the cycle right after the first block's last bit. The two data enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pol_sel | input | 1 | Polarity choice for `roe`, captured during `rst` |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| ce_n | input | 1 | Active-low chip select |
| roe | input | 1 | Combined reset / output-enable |
| load_we | input | 1 | Word write strobe for the store |
| load_addr | input | log2(DEPTH/WORD_W) | Word index to write |
| load_word | input | WORD_W | Word to write, LSB is the lowest bit address |
| dout | output | 1 | Serial data (0 when not enabled) |
| dout_en | output | 1 | Drive enable for `dout` |
| ceo_n | output | 1 | Active-low chain select for the next block |

## Verification
The bench builds two chained instances with `DEPTH` = 256 and `WORD_W` = 32. Each instance then holds eight words, so both reach their last bit within a few hundred clocks. This puts the end-of-memory handover, the sticky and follow behaviour of `ceo_n`, and the hold after completion within reach. The word width still leaves several word boundaries inside each stream, which exercises the word fetch ahead of the counter as the address crosses from one word to the next.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Operating condition decoded from the control pins, highest priority first.
  typedef enum logic [1:0] {
    SCR_PROG  = 2'd0,
    SCR_RESET = 2'd1,
    SCR_IDLE  = 2'd2,
    SCR_RUN   = 2'd3
  } scr_mode_e;

  function automatic scr_mode_e scr_decode(input logic ser_en,
                                           input logic oe_act,
                                           input logic ce_n);
    if (!ser_en)      return SCR_PROG;
    else if (!oe_act) return SCR_RESET;
    else if (ce_n)    return SCR_IDLE;
    else              return SCR_RUN;
  endfunction

endpackage

// File: rtl/scr_bit_store.sv
module scr_bit_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 2048,
  parameter int WAW    = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WAW-1:0]    waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WAW-1:0]    raddr,
  output logic [WORD_W-1:0] rword
);

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rword <= mem[raddr];
  end

endmodule

// File: rtl/scr_seq_ctrl.sv
module scr_seq_ctrl
  import scr_pkg::*;
#(
  parameter int DEPTH  = 65536,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pol_sel,
  input  logic              ser_en,
  input  logic              ce_n,
  input  logic              roe,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              done_q,
  output logic              stream_en
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic      pol_q;
  logic      oe_act;
  logic      done_nxt;
  scr_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) pol_q <= pol_sel;
  end

  assign oe_act = roe ^ pol_q;
  assign mode   = scr_decode(ser_en, oe_act, ce_n);

  always_comb begin
    addr_nxt = addr_q;
    done_nxt = done_q;
    if (rst) begin
      addr_nxt = '0;
      done_nxt = 1'b0;
    end else begin
      case (mode)
        SCR_RESET: begin
          addr_nxt = '0;
          done_nxt = 1'b0;
        end
        SCR_RUN: begin
          if (!done_q) begin
            if (addr_q == LAST) done_nxt = 1'b1;
            else                addr_nxt = addr_q + ADDR_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_nxt;
    done_q <= done_nxt;
  end

  assign stream_en = !rst && (mode == SCR_RUN) && !done_q;

  // R2
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en && !(roe ^ pol_q)) |=> (addr_q == '0 && !done_q));

  // R3
  pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(pol_q));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (stream_en && addr_q != LAST) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R5
  standby_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_en && oe_act && ce_n) |=> ($stable(addr_q) && $stable(done_q)));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !(ser_en && !oe_act)) |=> done_q);

  // R8
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> ($stable(addr_q) && $stable(done_q)));

endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int WORD_W = 32,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              stream_en,
  input  logic              done_q,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [WORD_W-1:0] rword,
  output logic              dout,
  output logic              dout_en,
  output logic              ceo_n
);

  assign dout_en = stream_en;
  assign dout    = stream_en & rword[bit_idx];
  assign ceo_n   = !(done_q && !ce_n);

  // R7
  ceo_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !ceo_n |-> !dout_en);

  // R7
  ceo_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |-> ceo_n);

endmodule

// File: rtl/serial_cfg_reader.sv
module serial_cfg_reader #(
  parameter int DEPTH  = 65536,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int WORDS  = DEPTH / WORD_W,
  localparam int WAW    = ADDR_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pol_sel,
  input  logic              ser_en,
  input  logic              ce_n,
  input  logic              roe,
  input  logic              load_we,
  input  logic [WAW-1:0]    load_addr,
  input  logic [WORD_W-1:0] load_word,
  output logic              dout,
  output logic              dout_en,
  output logic              ceo_n
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic              done_q;
  logic              stream_en;
  logic [WORD_W-1:0] rword;

  scr_seq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pol_sel   (pol_sel),
    .ser_en    (ser_en),
    .ce_n      (ce_n),
    .roe       (roe),
    .addr_q    (addr_q),
    .addr_nxt  (addr_nxt),
    .done_q    (done_q),
    .stream_en (stream_en)
  );

  // The word read follows the address the counter is about to take, so the
  // registered word always matches addr_q after each edge.
  scr_bit_store #(.WORD_W(WORD_W), .WORDS(WORDS), .WAW(WAW)) u_store (
    .clk   (clk),
    .we    (load_we),
    .waddr (load_addr),
    .wdata (load_word),
    .raddr (addr_nxt[ADDR_W-1:BIT_W]),
    .rword (rword)
  );

  scr_out_stage #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .stream_en (stream_en),
    .done_q    (done_q),
    .bit_idx   (addr_q[BIT_W-1:0]),
    .rword     (rword),
    .dout      (dout),
    .dout_en   (dout_en),
    .ceo_n     (ceo_n)
  );

endmodule

// File: tb/serial_cfg_reader_bench.sv
`timescale 1ns/1ps
module serial_cfg_reader_bench;

  localparam int DEPTH  = 256;
  localparam int WORD_W = 32;
  localparam int WORDS  = DEPTH / WORD_W;
  localparam int WAW    = $clog2(WORDS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst, pol_sel, ser_en, ce_n, roe;
  logic              we_a, we_b;
  logic [WAW-1:0]    ld_addr;
  logic [WORD_W-1:0] ld_word;
  logic              dout_a, en_a, ceo_a;
  logic              dout_b, en_b, ceo_b;

  serial_cfg_reader #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_serial_cfg_reader (
    .clk(clk), .rst(rst), .pol_sel(pol_sel), .ser_en(ser_en), .ce_n(ce_n),
    .roe(roe), .load_we(we_a), .load_addr(ld_addr), .load_word(ld_word),
    .dout(dout_a), .dout_en(en_a), .ceo_n(ceo_a));

  serial_cfg_reader #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_serial_cfg_reader_nxt (
    .clk(clk), .rst(rst), .pol_sel(pol_sel), .ser_en(ser_en), .ce_n(ceo_a),
    .roe(roe), .load_we(we_b), .load_addr(ld_addr), .load_word(ld_word),
    .dout(dout_b), .dout_en(en_b), .ceo_n(ceo_b));

  int n_chk = 0;
  int n_bad = 0;
  logic exp_a [DEPTH];
  logic exp_b [DEPTH];

  function automatic logic [WORD_W-1:0] pat(input int dev, input int w);
    logic [WORD_W-1:0] v;
    v = WORD_W'(32'h6B8B4567 * (w + 1));
    return v ^ (dev != 0 ? WORD_W'(32'hF0F01234) : WORD_W'(32'h1357ACE5));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Value seen on the shared data line: 2 stands for floating.
  function automatic int bus_val();
    if (en_a && en_b) return 3;
    if (en_a) return int'(dout_a);
    if (en_b) return int'(dout_b);
    return 2;
  endfunction

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 dout_en idle after reset", int'(en_a), 0);
    chk("R1 ceo_n high after reset", int'(ceo_a), 1);
    chk("R1 chained enable idle", int'(en_b), 0);
  endtask

  task automatic t_load();
    @(negedge clk);
    ser_en = 1'b0; ce_n = 1'b0; roe = 1'b1;
    for (int w = 0; w < WORDS; w++) begin
      @(negedge clk);
      we_a = 1'b1; we_b = 1'b1;
      ld_addr = WAW'(w);
      ld_word = pat(0, w);
      #1;
      chk("R8 no read-out in programming mode", int'(en_a), 0);
      @(negedge clk);
      we_a = 1'b0;
      ld_word = pat(1, w);
      for (int b = 0; b < WORD_W; b++) begin
        exp_a[w*WORD_W+b] = pat(0, w)[b];
        exp_b[w*WORD_W+b] = pat(1, w)[b];
      end
    end
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stream_standby_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) ser_en = 1'b1;
      #1;
      chk("R4 enable while streaming", int'(en_a), 1);
      chk("R4 bit value", int'(dout_a), int'(exp_a[i]));
      chk("R9 second block idle", int'(en_b), 0);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      ce_n = 1'b1;
      #1;
      chk("R5 standby floats data", int'(en_a), 0);
    end
    for (int i = 40; i < 60; i++) begin
      @(negedge clk);
      ce_n = 1'b0;
      #1;
      chk("R5 resume at next bit", int'(dout_a), int'(exp_a[i]));
    end
    @(negedge clk);
    roe = 1'b0;
    #1;
    chk("R2 reset level floats data", int'(en_a), 0);
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    roe = 1'b1; ce_n = 1'b0;
    #1;
    chk("R2 restart enable", int'(en_a), 1);
    chk("R2 restart at bit 0", int'(dout_a), int'(exp_a[0]));
    @(negedge clk);
    #1;
    chk("R2 then bit 1", int'(dout_a), int'(exp_a[1]));
  endtask

  task automatic t_prog_hold();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ser_en = 1'b0;
      roe = k[0];
      #1;
      chk("R8 programming mode floats data", int'(en_a), 0);
    end
    @(negedge clk);
    ser_en = 1'b1; roe = 1'b1;
    #1;
    chk("R8 resume at held address", int'(dout_a), int'(exp_a[2]));
    chk("R8 enable after programming mode", int'(en_a), 1);
  endtask

  task automatic t_cascade();
    @(negedge clk);
    roe = 1'b0;
    for (int i = 0; i < 2*DEPTH; i++) begin
      @(negedge clk);
      if (i == 0) roe = 1'b1;
      #1;
      if (i < DEPTH) chk("R9 stream from first block", bus_val(), int'(exp_a[i]));
      else           chk("R9 stream from second block", bus_val(), int'(exp_b[i-DEPTH]));
      if (i == DEPTH - 1) chk("R7 chain select high before end", int'(ceo_a), 1);
      if (i == DEPTH)     chk("R7 chain select low at end", int'(ceo_a), 0);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk("R6 first block stays quiet", int'(en_a), 0);
      chk("R6 second block stays quiet", int'(en_b), 0);
    end
    chk("R7 chain select sticky low", int'(ceo_a), 0);
    chk("R7 second chain select low", int'(ceo_b), 0);
    @(negedge clk);
    ce_n = 1'b1;
    #1;
    chk("R7 chain select follows high", int'(ceo_a), 1);
    chk("R7 second chain select follows", int'(ceo_b), 1);
    @(negedge clk);
    ce_n = 1'b0;
    #1;
    chk("R7 chain select follows low", int'(ceo_a), 0);
    chk("R6 no restart without reset", int'(en_a), 0);
    @(negedge clk);
    roe = 1'b0;
    @(negedge clk);
    roe = 1'b1;
    #1;
    chk("R7 chain select high after reset", int'(ceo_a), 1);
    chk("R7 first block restarts at bit 0", bus_val(), int'(exp_a[0]));
  endtask

  task automatic t_polarity();
    @(negedge clk);
    rst = 1'b1; pol_sel = 1'b1; roe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; pol_sel = 1'b0; ce_n = 1'b0; roe = 1'b0;
    #1;
    chk("R3 inverted polarity enables on low", int'(en_a), 1);
    chk("R3 bit 0 under inverted polarity", int'(dout_a), int'(exp_a[0]));
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      #1;
      chk("R3 stream under inverted polarity", int'(dout_a), int'(exp_a[i]));
    end
    @(negedge clk);
    roe = 1'b1;
    #1;
    chk("R3 high is reset level", int'(en_a), 0);
    @(negedge clk);
    roe = 1'b0;
    #1;
    chk("R3 restart at bit 0", int'(dout_a), int'(exp_a[0]));
    chk("R3 pol_sel change outside reset ignored", int'(en_a), 1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; roe = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; pol_sel = 1'b0; ser_en = 1'b1; ce_n = 1'b1; roe = 1'b1;
    we_a = 1'b0; we_b = 1'b0; ld_addr = '0; ld_word = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_load();
    t_stream_standby_reset();
    t_prog_hold();
    t_cascade();
    t_polarity();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule